// File: doc/BRIEF.md
# Synchronous Framed Serial Port

This block moves 16-bit parallel words over a three-wire synchronous serial link: a serial clock, a frame sync and one data line in each direction. Data is organised in slots of 16 bits, sent most significant bit first. A frame is made of one to four slots, and frames follow each other without gaps while the port is enabled. Words to send wait in an eight-entry transmit FIFO. Received words are collected in an eight-entry receive FIFO. Both FIFOs use valid/ready handshakes.

As clock master, the port derives the serial clock from the system clock with an even divider. It drives the frame sync either on the first bit of each frame or on the last bit of every slot. Receive data is sampled on the falling edge and transmit data launched on the rising edge, or the other way round. As slave, the port takes the serial clock and sync from outside through synchronizers. It always samples on the falling edge, launches on the rising edge, and starts a frame at the edge where sync is seen.

A single write port updates the control fields. The enable bit can be written at any time. The other fields can be changed only while the port is disabled, so a running frame is never disturbed.

Top module: `frame_serial_port`

## Requirements
- R1: After reset the mode field reads 2'b10 (master), the port is disabled, `sck_o`, `sync_o`, `underrun` and `overrun` are low, `rx_valid` is low and `tx_ready` is high.
- R2: The mode field accepts 2'b00 (slave) and 2'b10 (master). A write of 2'b01 or 2'b11 leaves the previous mode in place.
- R3: A control write while the port is enabled changes only the enable bit. Mode, sync position, sampling edge, slot count and divider keep their values.
- R4: In enabled master mode, one period of `sck_o` lasts 2*(`cfg_div`+1) system clocks. While the port is disabled, `sck_o` is low.
- R5: Each slot carries one transmit word, MSB first. With `sd_o` looped back to `sd_i`, words arrive in the receive FIFO unchanged and in the order they were sent.
- R6: In master mode with `cfg_sync_last`=0, `sync_o` rises together with the first launched bit of each frame, that is every 16*(`cfg_slots_m1`+1) launch edges, starting with the first.
- R7: In master mode with `cfg_sync_last`=1, `sync_o` rises with the last (16th) bit of every slot.
- R8: In master mode, `sd_o` changes only when `sck_o` rises if `cfg_rise_samp`=0, and only when it falls if `cfg_rise_samp`=1. Receive data is sampled on the opposite edge.
- R9: In slave mode the port follows `sck_i`/`sync_i`. It launches on rising and samples on falling edges whatever the sync-position and sampling-edge bits say. A frame starts at the rising edge where `sync_i` is high. `sync_o` and `sck_o` stay low.
- R10: A slot that starts with an empty transmit FIFO is sent as all zeros and sets `underrun`, which stays set until reset.
- R11: A word completed while the receive FIFO is full is dropped and sets `overrun`, which stays set until reset. Words already held are kept.
- R12: Each FIFO holds 8 words. `tx_ready` goes low after 8 unsent words. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit written by the strobe |
| cfg_mode | input | 2 | Mode code: 00 slave, 10 master |
| cfg_sync_last | input | 1 | Sync position: 0 first bit of frame, 1 last bit of slot |
| cfg_rise_samp | input | 1 | Sampling edge: 0 sample falling, 1 sample rising |
| cfg_slots_m1 | input | 2 | Slots per frame minus one |
| cfg_div | input | 4 | Master clock divider, half period minus one |
| mode_o | output | 2 | Current mode field |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO has space |
| rx_data | output | 16 | Oldest received word |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Consumer takes the received word |
| sck_o | output | 1 | Serial clock driven in master mode |
| sync_o | output | 1 | Frame sync driven in master mode |
| sd_o | output | 1 | Serial transmit data |
| sck_i | input | 1 | Serial clock from outside in slave mode |
| sync_i | input | 1 | Frame sync from outside in slave mode |
| sd_i | input | 1 | Serial receive data |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The hardest state to reach is receive overrun. It requires a full receive FIFO while serial words keep arriving, and those words would normally be drained. The bench holds `rx_ready` low, loads eight words while the port is disabled, and lets the looped-back link run past nine slots. It then checks that the eight held words come out intact and the flag is set. Slave operation is driven by a bit-banged external master whose sampling and launch timing follows R9. In that run the sampling-edge and sync-position bits are deliberately set, to show they are ignored.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int SLOT_W     = 16;
  localparam int DIV_W      = 4;
  localparam int SLOT_CNT_W = 2;

  localparam logic [1:0] MODE_SLAVE  = 2'b00;
  localparam logic [1:0] MODE_MASTER = 2'b10;

  typedef struct packed {
    logic [1:0]            mode;
    logic                  sync_last;
    logic                  rise_samp;
    logic [SLOT_CNT_W-1:0] slots_m1;
    logic [DIV_W-1:0]      div;
  } cfg_t;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = d;
    end else begin : g_many
      always_comb chain_n = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          push, pop;

  assign in_ready  = (cnt_q != FULL_CNT);
  assign out_valid = (cnt_q != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp_q];

  always_comb begin
    wp_n  = push ? wp_q + 1'b1 : wp_q;
    rp_n  = pop  ? rp_q + 1'b1 : rp_q;
    cnt_n = cnt_q;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= in_data;
  end
endmodule

// File: rtl/sfp_edges.sv
module sfp_edges #(
  parameter int DW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          master,
  input  logic [DW-1:0] div,
  input  logic          sck_ext,
  input  logic          sync_ext,
  output logic          sck_o,
  output logic          rise_p,
  output logic          fall_p,
  output logic          sync_s
);
  logic [DW-1:0] cnt_q, cnt_n;
  logic          sck_q, sck_n;
  logic          tick, m_on;
  logic          ext_s, ext_d_q;

  sfp_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_ext), .q(ext_s)
  );
  sfp_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_ext), .q(sync_s)
  );

  assign m_on = run && master;
  assign tick = m_on && (cnt_q == div);

  always_comb begin
    cnt_n = (!m_on || tick) ? '0 : cnt_q + 1'b1;
    sck_n = !m_on ? 1'b0 : (tick ? !sck_q : sck_q);
    if (master) begin
      rise_p = tick && !sck_q;
      fall_p = tick && sck_q;
    end else begin
      rise_p = run && ext_s && !ext_d_q;
      fall_p = run && !ext_s && ext_d_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      ext_d_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      sck_q   <= sck_n;
      ext_d_q <= ext_s;
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/sfp_engine.sv
module sfp_engine #(
  parameter int W  = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          master,
  input  logic          sync_last,
  input  logic          rise_samp,
  input  logic [SW-1:0] slots_m1,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic          sync_s,
  input  logic          sd_i,
  input  logic [W-1:0]  tx_word,
  input  logic          tx_avail,
  input  logic          rx_space,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [W-1:0]  rx_word,
  output logic          sd_o,
  output logic          sync_o,
  output logic          underrun,
  output logic          overrun
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W-1);

  logic          started_q, started_n;
  logic [BW-1:0] bitc_q, bitc_n, rxc_q, rxc_n, pos_bit;
  logic [SW-1:0] slotc_q, slotc_n, pos_slot;
  logic [W-1:0]  txsh_q, txsh_n, rxsh_q, rxsh_n, word;
  logic          sd_q, sd_n, sync_q, sync_n, arm_q, arm_n;
  logic          und_q, und_n, ovr_q, ovr_n;
  logic          launch, sample, realign, do_launch, slot_start, frame_end, word_done;

  always_comb begin
    launch     = rise_samp ? fall_p : rise_p;
    sample     = rise_samp ? rise_p : fall_p;
    realign    = !master && sync_s;
    pos_bit    = realign ? '0 : bitc_q;
    pos_slot   = realign ? '0 : slotc_q;
    do_launch  = run && launch && (master || started_q || realign);
    slot_start = (pos_bit == '0);
    frame_end  = (pos_bit == LAST_BIT) && (pos_slot == slots_m1);
    word       = slot_start ? (tx_avail ? tx_word : '0) : txsh_q;
    word_done  = run && sample && arm_q && (rxc_q == LAST_BIT);
    tx_pop     = do_launch && slot_start && tx_avail;
    rx_push    = word_done && rx_space;
    rx_word    = {rxsh_q[W-2:0], sd_i};
  end

  always_comb begin
    started_n = started_q;
    bitc_n    = bitc_q;
    slotc_n   = slotc_q;
    rxc_n     = rxc_q;
    txsh_n    = txsh_q;
    rxsh_n    = rxsh_q;
    sd_n      = sd_q;
    sync_n    = sync_q;
    arm_n     = arm_q;
    und_n     = und_q;
    ovr_n     = ovr_q;
    if (!run) begin
      started_n = 1'b0;
      bitc_n    = '0;
      slotc_n   = '0;
      sd_n      = 1'b0;
      sync_n    = 1'b0;
      arm_n     = 1'b0;
    end else begin
      if (do_launch) begin
        sd_n      = word[W-1];
        txsh_n    = {word[W-2:0], 1'b0};
        sync_n    = master && (sync_last ? (pos_bit == LAST_BIT)
                                         : (slot_start && pos_slot == '0));
        bitc_n    = (pos_bit == LAST_BIT) ? '0 : pos_bit + 1'b1;
        slotc_n   = (pos_bit != LAST_BIT) ? pos_slot :
                    (frame_end ? '0 : pos_slot + 1'b1);
        started_n = master || !frame_end;
        arm_n     = 1'b1;
        rxc_n     = pos_bit;
        if (slot_start && !tx_avail) und_n = 1'b1;
      end
      if (sample && arm_q) begin
        rxsh_n = {rxsh_q[W-2:0], sd_i};
        arm_n  = 1'b0;
        if (word_done && !rx_space) ovr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      bitc_q    <= '0;
      slotc_q   <= '0;
      rxc_q     <= '0;
      txsh_q    <= '0;
      rxsh_q    <= '0;
      sd_q      <= 1'b0;
      sync_q    <= 1'b0;
      arm_q     <= 1'b0;
      und_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      started_q <= started_n;
      bitc_q    <= bitc_n;
      slotc_q   <= slotc_n;
      rxc_q     <= rxc_n;
      txsh_q    <= txsh_n;
      rxsh_q    <= rxsh_n;
      sd_q      <= sd_n;
      sync_q    <= sync_n;
      arm_q     <= arm_n;
      und_q     <= und_n;
      ovr_q     <= ovr_n;
    end
  end

  assign sd_o     = sd_q;
  assign sync_o   = sync_q;
  assign underrun = und_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/frame_serial_port.sv
module frame_serial_port
  import sfp_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RESET   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_en,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_sync_last,
  input  logic                  cfg_rise_samp,
  input  logic [SLOT_CNT_W-1:0] cfg_slots_m1,
  input  logic [DIV_W-1:0]      cfg_div,
  output logic [1:0]            mode_o,
  input  logic [SLOT_W-1:0]     tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic [SLOT_W-1:0]     rx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic                  sck_o,
  output logic                  sync_o,
  output logic                  sd_o,
  input  logic                  sck_i,
  input  logic                  sync_i,
  input  logic                  sd_i,
  output logic                  underrun,
  output logic                  overrun
);
  logic              rst_meta_q, rst_int_n;
  cfg_t              cfg_q, cfg_n;
  logic              en_q, en_n;
  logic              master;
  logic              rise_p, fall_p, sync_s;
  logic [SLOT_W-1:0] txf_word, rx_word;
  logic              txf_avail, tx_pop, rx_space, rx_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  always_comb begin
    cfg_n = cfg_q;
    en_n  = en_q;
    if (cfg_wr) begin
      en_n = cfg_en;
      if (!en_q) begin
        if (cfg_mode == MODE_SLAVE || cfg_mode == MODE_MASTER) cfg_n.mode = cfg_mode;
        cfg_n.sync_last = cfg_sync_last;
        cfg_n.rise_samp = cfg_rise_samp;
        cfg_n.slots_m1  = cfg_slots_m1;
        cfg_n.div       = cfg_div;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q            <= 1'b0;
      cfg_q.mode      <= MODE_MASTER;
      cfg_q.sync_last <= 1'b0;
      cfg_q.rise_samp <= 1'b0;
      cfg_q.slots_m1  <= '0;
      cfg_q.div       <= DIV_W'(DIV_RESET);
    end else begin
      en_q  <= en_n;
      cfg_q <= cfg_n;
    end
  end

  assign master = (cfg_q.mode == MODE_MASTER);
  assign mode_o = cfg_q.mode;

  sfp_edges #(.DW(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_int_n), .run(en_q), .master(master), .div(cfg_q.div),
    .sck_ext(sck_i), .sync_ext(sync_i), .sck_o(sck_o),
    .rise_p(rise_p), .fall_p(fall_p), .sync_s(sync_s)
  );

  sfp_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .out_data(txf_word), .out_valid(txf_avail), .out_ready(tx_pop)
  );

  sfp_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n),
    .in_data(rx_word), .in_valid(rx_push), .in_ready(rx_space),
    .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready)
  );

  sfp_engine #(.W(SLOT_W), .SW(SLOT_CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_int_n), .run(en_q), .master(master),
    .sync_last(master && cfg_q.sync_last), .rise_samp(master && cfg_q.rise_samp),
    .slots_m1(cfg_q.slots_m1), .rise_p(rise_p), .fall_p(fall_p), .sync_s(sync_s),
    .sd_i(sd_i), .tx_word(txf_word), .tx_avail(txf_avail), .rx_space(rx_space),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sd_o(sd_o), .sync_o(sync_o), .underrun(underrun), .overrun(overrun)
  );
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input cfg_t              cfg_q,
  input logic              sck_o,
  input logic              sync_o,
  input logic              sd_o,
  input logic              underrun,
  input logic              overrun,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [SLOT_W-1:0] rx_data
);
  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MODE_SLAVE) || (cfg_q.mode == MODE_MASTER));

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(cfg_q));

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !sck_o);

  // R8
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && cfg_q.mode == MODE_MASTER && sd_o != $past(sd_o))
      |-> (sck_o != $past(sck_o)) && (sck_o == !cfg_q.rise_samp));

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MODE_SLAVE) |-> (!sync_o && !sck_o));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind frame_serial_port sfp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .cfg_q(cfg_q),
  .sck_o(sck_o), .sync_o(sync_o), .sd_o(sd_o),
  .underrun(underrun), .overrun(overrun),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/frame_serial_port_test.sv
module frame_serial_port_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        cfg_wr, cfg_en, cfg_sync_last, cfg_rise_samp;
  logic [1:0]  cfg_mode, cfg_slots_m1, mode_o;
  logic [3:0]  cfg_div;
  logic [15:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic        sck_o, sync_o, sd_o, sck_i, sync_i, sd_drv, loop_en, sd_in;
  logic        underrun, overrun;

  assign sd_in = loop_en ? sd_o : sd_drv;

  frame_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_sync_last(cfg_sync_last), .cfg_rise_samp(cfg_rise_samp),
    .cfg_slots_m1(cfg_slots_m1), .cfg_div(cfg_div), .mode_o(mode_o),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sck_o(sck_o), .sync_o(sync_o), .sd_o(sd_o),
    .sck_i(sck_i), .sync_i(sync_i), .sd_i(sd_in),
    .underrun(underrun), .overrun(overrun)
  );

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  int sync_pos[$];
  int cyc = 0, rise_n = 0, fall_n = 0, rise_t = 0, rise_t_prev = 0;
  int edge_n = 0, edge_bad = 0, sync_seen = 0;
  bit track = 0, redg_t = 0;
  logic p_sck = 0, p_sync = 0, p_sd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  // monitor: scoreboard pop plus serial-line tracking
  always @(negedge clk) begin
    logic [15:0] e;
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(rx_data == e, "R5", "received word", rx_data, e);
      end else begin
        chk(rx_data == 16'h0, "R10", "underrun fill word", rx_data, 0);
      end
    end
    if (sck_o && !p_sck) begin rise_n++; rise_t_prev = rise_t; rise_t = cyc; end
    if (!sck_o && p_sck) fall_n++;
    if (sync_o && !p_sync) sync_pos.push_back(redg_t ? fall_n : rise_n);
    if (sync_o) sync_seen++;
    if (track && sd_o != p_sd) begin
      edge_n++;
      if (!(sck_o != p_sck && sck_o == !redg_t)) edge_bad++;
    end
    p_sck = sck_o; p_sync = sync_o; p_sd = sd_o;
  end

  task automatic clear_track();
    rise_n = 0; fall_n = 0; edge_n = 0; edge_bad = 0; sync_seen = 0;
    sync_pos.delete();
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_wr = 0; cfg_en = 0; cfg_mode = 2'b10; cfg_sync_last = 0;
    cfg_rise_samp = 0; cfg_slots_m1 = 0; cfg_div = 3; tx_data = 0; tx_valid = 0;
    rx_ready = 1; sck_i = 0; sync_i = 0; sd_drv = 0; loop_en = 1; track = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input bit en, input logic [1:0] mode, input bit sl, input bit rs,
                     input logic [1:0] slots, input logic [3:0] div);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_en = en; cfg_mode = mode; cfg_sync_last = sl;
    cfg_rise_samp = rs; cfg_slots_m1 = slots; cfg_div = div;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  // driver: offers a word and records it as expected once accepted
  task automatic push_tx(input logic [15:0] w, input bit expect_back);
    @(posedge clk); #1;
    tx_data = w; tx_valid = 1;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
    tx_valid = 0;
    if (expect_back) exp_q.push_back(w);
  endtask

  // external master for slave mode: launch on rise, sample on fall
  task automatic slave_frame(input logic [15:0] w, output logic [15:0] got);
    for (int i = 0; i < 16; i++) begin
      sync_i = (i == 0);
      sd_drv = w[15-i];
      repeat (8) @(posedge clk); #1;
      sck_i = 1;
      repeat (8) @(posedge clk); #1;
      got[15-i] = sd_o;
      sck_i = 0;
      repeat (8) @(posedge clk); #1;
    end
    sync_i = 0;
    repeat (16) @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] got;
    do_reset();
    // R1 reset state
    chk(mode_o == 2'b10, "R1", "mode after reset", mode_o, 2);
    chk(!sck_o && !sync_o, "R1", "serial outputs idle", {sck_o, sync_o}, 0);
    chk(!underrun && !overrun, "R1", "flags clear", {underrun, overrun}, 0);
    chk(!rx_valid && tx_ready, "R1", "fifo state", {rx_valid, tx_ready}, 1);

    // R2 prohibited codes keep previous mode
    cfg(0, 2'b01, 0, 0, 0, 3);
    chk(mode_o == 2'b10, "R2", "mode after 01 write", mode_o, 2);
    cfg(0, 2'b00, 0, 0, 0, 3);
    chk(mode_o == 2'b00, "R2", "mode after 00 write", mode_o, 0);
    cfg(0, 2'b11, 0, 0, 0, 3);
    chk(mode_o == 2'b00, "R2", "mode after 11 write", mode_o, 0);

    // Loopback A: master, sync on first bit, 2 slots, edge 0, divider 3
    cfg(0, 2'b10, 0, 0, 2'd1, 4'd3);
    push_tx(16'hA5C3, 1); push_tx(16'h1234, 1); push_tx(16'hFFFF, 1);
    push_tx(16'h8001, 1); push_tx(16'h0F0F, 1); push_tx(16'h7E81, 1);
    clear_track(); redg_t = 0; track = 1;
    cfg(1, 2'b10, 0, 0, 2'd1, 4'd3);
    repeat (300) @(posedge clk); #1;
    cfg(1, 2'b00, 1, 1, 2'd0, 4'd0);
    chk(mode_o == 2'b10, "R3", "mode write while enabled", mode_o, 2);
    repeat (700) @(posedge clk); #1;
    chk(rise_t - rise_t_prev == 8, "R3", "period after locked div write", rise_t - rise_t_prev, 8);
    chk(rise_t - rise_t_prev == 8, "R4", "sck period div=3", rise_t - rise_t_prev, 8);
    chk(sync_pos.size() >= 2 && sync_pos[0] == 1, "R6", "first sync at rise",
        sync_pos.size() > 0 ? sync_pos[0] : -1, 1);
    chk(sync_pos.size() >= 2 && sync_pos[1] == 33, "R6", "second sync at rise",
        sync_pos.size() > 1 ? sync_pos[1] : -1, 33);
    chk(edge_n > 0 && edge_bad == 0, "R8", "sd_o changes on rising sck", edge_bad, 0);
    chk(underrun == 1, "R10", "underrun after tx empty", underrun, 1);
    track = 0;
    cfg(0, 2'b10, 0, 0, 2'd1, 4'd3);
    repeat (200) @(posedge clk); #1;
    chk(sck_o == 0, "R4", "sck idle when disabled", sck_o, 0);
    chk(exp_q.size() == 0, "R5", "all loopback words received", exp_q.size(), 0);

    // Loopback B: sync on last bit of slot, edge 1, 1 slot, divider 1
    do_reset();
    cfg(0, 2'b10, 1, 1, 2'd0, 4'd1);
    push_tx(16'hC3A5, 1); push_tx(16'h5AA5, 1); push_tx(16'h0001, 1);
    clear_track(); redg_t = 1; track = 1;
    cfg(1, 2'b10, 1, 1, 2'd0, 4'd1);
    repeat (600) @(posedge clk); #1;
    chk(sync_pos.size() >= 2 && sync_pos[0] == 16, "R7", "first sync at fall",
        sync_pos.size() > 0 ? sync_pos[0] : -1, 16);
    chk(sync_pos.size() >= 2 && sync_pos[1] == 32, "R7", "second sync at fall",
        sync_pos.size() > 1 ? sync_pos[1] : -1, 32);
    chk(edge_n > 0 && edge_bad == 0, "R8", "sd_o changes on falling sck", edge_bad, 0);
    track = 0; redg_t = 0;
    cfg(0, 2'b10, 1, 1, 2'd0, 4'd1);
    repeat (200) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R5", "edge-1 loopback words received", exp_q.size(), 0);

    // Slave: sync/edge bits set but must be ignored
    do_reset();
    loop_en = 0;
    cfg(0, 2'b00, 1, 1, 2'd0, 4'd3);
    cfg(1, 2'b00, 1, 1, 2'd0, 4'd3);
    clear_track();
    push_tx(16'h3C5A, 0);
    exp_q.push_back(16'h9E61);
    slave_frame(16'h9E61, got);
    chk(got == 16'h3C5A, "R9", "slave transmit word", got, 16'h3C5A);
    chk(exp_q.size() == 0, "R9", "slave receive word delivered", exp_q.size(), 0);
    chk(underrun == 0, "R9", "no underrun with data", underrun, 0);
    exp_q.push_back(16'h0F0F);
    slave_frame(16'h0F0F, got);
    chk(got == 16'h0000, "R10", "slave underrun slot zeros", got, 0);
    chk(underrun == 1, "R10", "slave underrun flag", underrun, 1);
    chk(exp_q.size() == 0, "R9", "second slave word delivered", exp_q.size(), 0);
    chk(sync_seen == 0, "R9", "sync_o quiet in slave", sync_seen, 0);
    chk(mode_o == 2'b00, "R2", "slave mode held", mode_o, 0);
    cfg(0, 2'b00, 0, 0, 2'd0, 4'd3);

    // Overrun: hold receive FIFO full
    do_reset();
    cfg(0, 2'b10, 0, 0, 2'd0, 4'd1);
    rx_ready = 0;
    for (int k = 0; k < 8; k++) push_tx(16'h1111 * (k + 1), 1);
    @(negedge clk);
    chk(tx_ready == 0, "R12", "tx full after 8 words", tx_ready, 0);
    cfg(1, 2'b10, 0, 0, 2'd0, 4'd1);
    repeat (1500) @(posedge clk); #1;
    chk(overrun == 1, "R11", "overrun flag", overrun, 1);
    chk(rx_valid == 1, "R12", "rx holds words", rx_valid, 1);
    cfg(0, 2'b10, 0, 0, 2'd0, 4'd1);
    repeat (20) @(posedge clk); #1;
    rx_ready = 1;
    repeat (40) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R11", "held words intact", exp_q.size(), 0);
    chk(overrun == 1, "R11", "overrun stays set", overrun, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule